// File: doc/BRIEF.md
# Button-Stepped Random LED Display Controller

This block sits between a free-running pseudorandom generator and a bank of eight LEDs. It issues a one-cycle step strobe to the generator and shows the top byte of the 64-bit word the generator returns. A slow interval timer produces a step every one and a half seconds. A push-button can also request a step at any time.

The raw button passes through a two-flop synchroniser and then a debouncer. The debouncer takes a new level only after the synchronised input has disagreed with the held level for a parameterised number of consecutive cycles. A rising-edge detector turns each accepted press into a single-cycle pulse. The timer tick and the button pulse are ORed into one registered strobe. One cycle after each strobe, the LED register captures bits 63:56 of the generator word. By then the generator has had time to present its new value.

All timing is derived from a clock-frequency parameter. This lets a bench run the block with intervals of a few dozen cycles.

Top module: `prng_led_stepper`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `step_o` is 0 and `led_o` is 0.
- R2: With the button idle, `step_o` is first high after exactly TERM+1 rising clock edges with reset low, where TERM = CLK_HZ*3/2 - 1. It is then high once every TERM+1 cycles.
- R3: The button is synchronised through two flip-flops. Suppose `btn_raw` goes high before rising edge e0 and stays high. Then `step_o` is first high after edge e(HOLD_CYCLES+3), which is HOLD_CYCLES+4 edges counted from e0 inclusive.
- R4: A button level lasting fewer than HOLD_CYCLES sampled cycles produces no step. A level lasting exactly HOLD_CYCLES cycles is accepted.
- R5: Each accepted press produces exactly one step. Holding the button produces no further step, and releasing it produces none.
- R6: `step_o` is high for exactly one cycle when a timer tick and a button pulse fall in the same cycle.
- R7: `led_o` takes `word_i[63:56]` at the clock edge one cycle after `step_o` was high. At every other edge it holds its value, even if `word_i` changes.
- R8: A button step does not restart the interval timer; the timed steps keep their TERM+1 spacing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Unsynchronised push-button level |
| step_o | output | 1 | One-cycle request to advance the generator |
| word_i | input | 64 | Current generator output word |
| led_o | output | 8 | LED drive, top byte of the captured word |

## Verification
The bench targets several corner cases, each with the failure it would expose:
- A button glitch one cycle shorter than the debounce window, and one exactly as long as it. A debouncer with an off-by-one threshold would step on the first or miss the second.
- Press latency, counted edge by edge. A missing or extra synchroniser stage, or an extra register in the edge detector, shifts the first strobe.
- A press timed so that its pulse lands in the same cycle as the timer tick. A design that kept the two sources apart would emit a two-cycle strobe.
- A change of the generator word while no step is pending. A design that loads the LEDs every cycle, or on the strobe instead of after it, would show the wrong byte.

// File: rtl/pls_pkg.sv
package pls_pkg;
    localparam int WORD_W = 64;
    localparam int LED_W  = 8;

    // Terminal count of the slow interval: one and a half seconds of clocks, minus one
    function automatic longint interval_term(input longint clk_hz);
        return (clk_hz * 3) / 2 - 1;
    endfunction
endpackage

// File: rtl/pls_sync2.sv
module pls_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout = st_q.chain[STAGES-1];
endmodule

// File: rtl/pls_debounce.sv
module pls_debounce #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] run;
    } db_state_t;

    db_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (din != st_q.level) begin
            if (st_q.run == LAST) begin
                st_d.level = din;
                st_d.run   = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign level = st_q.level;

    // R4
    level_needs_full_run_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.level != $past(st_q.level)) |-> ($past(st_q.run) == LAST));

    // R4
    run_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.run <= LAST);
endmodule

// File: rtl/pls_rise_pulse.sv
module pls_rise_pulse (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);
    typedef struct packed {
        logic prev;
        logic pulse;
    } rp_state_t;

    rp_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.prev  = level;
        st_d.pulse = level & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pulse = st_q.pulse;

    // R5
    pulse_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.pulse |=> !st_q.pulse);
endmodule

// File: rtl/pls_interval.sv
module pls_interval #(
    parameter longint TERM = 59
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = $clog2(TERM + 1);
    localparam logic [CW-1:0] TERM_V = CW'(TERM);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } iv_state_t;

    iv_state_t st_d, st_q;
    logic      at_end;

    assign at_end = (st_q.cnt == TERM_V);

    always_comb begin
        st_d = st_q;
        if (at_end) st_d.cnt = '0;
        else        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tick = at_end;

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= TERM_V);

    // R8
    restart_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (st_q.cnt == '0));

    // R6
    tick_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/prng_led_stepper.sv
module prng_led_stepper #(
    parameter longint CLK_HZ      = 50_000_000,
    parameter int     HOLD_CYCLES = 500_000,
    parameter int     SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      btn_raw,
    output logic                      step_o,
    input  logic [pls_pkg::WORD_W-1:0] word_i,
    output logic [pls_pkg::LED_W-1:0]  led_o
);
    import pls_pkg::*;

    localparam longint TERM   = interval_term(CLK_HZ);
    localparam int     LED_LO = WORD_W - LED_W;

    typedef struct packed {
        logic             step;
        logic             load;
        logic [LED_W-1:0] led;
    } top_state_t;

    top_state_t st_d, st_q;
    logic btn_sync, btn_level, btn_pulse, tick_w;
    logic unused_word_bits;

    assign unused_word_bits = ^word_i[LED_LO-1:0];

    pls_sync2 #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk), .rst (rst), .din (btn_raw), .dout (btn_sync)
    );

    pls_debounce #(.HOLD(HOLD_CYCLES)) deb_i (
        .clk (clk), .rst (rst), .din (btn_sync), .level (btn_level)
    );

    pls_rise_pulse edge_i (
        .clk (clk), .rst (rst), .level (btn_level), .pulse (btn_pulse)
    );

    pls_interval #(.TERM(TERM)) timer_i (
        .clk (clk), .rst (rst), .tick (tick_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.step = tick_w | btn_pulse;
        st_d.load = st_q.step;
        if (st_q.load) st_d.led = word_i[WORD_W-1:LED_LO];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign step_o = st_q.step;
    assign led_o  = st_q.led;

    // R7
    led_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !st_q.load |=> $stable(st_q.led));

    // R7
    load_follows_step_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.step |=> st_q.load);
endmodule

// File: tb/prng_led_stepper_tb.sv
module prng_led_stepper_tb_top;
    localparam longint CLK_HZ = 40;
    localparam int     HOLD   = 4;
    localparam int     TERM   = 59;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        btn_raw = 1'b0;
    logic        step_o;
    logic [63:0] word_i;
    logic [7:0]  led_o;
    logic [63:0] gen_q;
    logic [63:0] noise = 64'h0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    prng_led_stepper #(.CLK_HZ(CLK_HZ), .HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) dut_i (
        .clk (clk), .rst (rst), .btn_raw (btn_raw),
        .step_o (step_o), .word_i (word_i), .led_o (led_o)
    );

    // Stand-in generator: advances when strobed
    always @(posedge clk) begin
        if (rst) gen_q <= 64'h9E37_79B9_7F4A_7C15;
        else if (step_o) gen_q <= gen_q * 64'd6364136223846793005 + 64'd1442695040888963407;
    end
    assign word_i = gen_q ^ noise;

    // Behavioural reference model
    bit   sq[$];
    bit   m_db, m_prev, m_pulse, m_step, m_load;
    int   m_run, m_tcnt;
    logic [7:0] m_led;

    always @(posedge clk) begin
        bit s, tk, n_db, n_pulse;
        int n_run;
        if (rst) begin
            sq = {1'b0, 1'b0};
            m_db = 0; m_prev = 0; m_pulse = 0; m_step = 0; m_load = 0;
            m_run = 0; m_tcnt = 0; m_led = 8'h00;
        end else begin
            s  = sq.pop_front();
            sq.push_back(btn_raw);
            tk = (m_tcnt == TERM);
            n_db = m_db; n_run = 0;
            if (s != m_db) begin
                if (m_run == HOLD - 1) n_db = s;
                else n_run = m_run + 1;
            end
            n_pulse = m_db && !m_prev;
            if (m_load) m_led = word_i[63:56];
            m_load  = m_step;
            m_step  = tk || m_pulse;
            m_prev  = m_db;
            m_pulse = n_pulse;
            m_db    = n_db;
            m_run   = n_run;
            m_tcnt  = tk ? 0 : m_tcnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison
    always @(negedge clk) begin
        if (!rst) begin
            check(step_o == m_step, "R6 step vs model", step_o, m_step);
            check(led_o == m_led, "R7 led vs model", led_o, m_led);
        end
    end

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; btn_raw = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic count_steps(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (step_o) cnt++;
        end
    endtask

    task automatic edges_to_step(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!step_o && n < 500);
    endtask

    initial begin
        int n, c;
        logic [7:0] held, w;
        // R1
        repeat (2) @(negedge clk);
        check(step_o == 0 && led_o == 0, "R1 during reset", {step_o, led_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(step_o == 0 && led_o == 0, "R1 after release", {step_o, led_o}, 0);

        // R2 first timed step and spacing, R8
        do_reset();
        edges_to_step(n);
        check(n == TERM + 1, "R2 first tick", n, TERM + 1);
        edges_to_step(n);
        check(n == TERM + 1, "R2 tick spacing", n, TERM + 1);

        // R3 latency, R5 hold/release
        do_reset();
        repeat (5) @(negedge clk);
        btn_raw = 1'b1;
        edges_to_step(n);
        check(n == HOLD + 4, "R3 press latency", n, HOLD + 4);
        count_steps(25, c);
        check(c == 0, "R5 hold gives no step", c, 0);
        btn_raw = 1'b0;
        count_steps(15, c);
        check(c == 0, "R5 release gives no step", c, 0);

        // R4 short glitch rejected, exact window accepted
        do_reset();
        repeat (3) @(negedge clk);
        btn_raw = 1'b1;
        repeat (HOLD - 1) @(negedge clk);
        btn_raw = 1'b0;
        count_steps(25, c);
        check(c == 0, "R4 short glitch ignored", c, 0);
        do_reset();
        repeat (3) @(negedge clk);
        btn_raw = 1'b1;
        repeat (HOLD) @(negedge clk);
        btn_raw = 1'b0;
        count_steps(25, c);
        check(c == 1, "R4 exact window accepted", c, 1);

        // R6 pulse coincides with tick
        do_reset();
        repeat (TERM - 7) @(negedge clk);
        btn_raw = 1'b1;
        count_steps(20, c);
        check(c == 1, "R6 coincident single cycle", c, 1);
        btn_raw = 1'b0;

        // R8 button step leaves timer alone
        do_reset();
        repeat (10) @(negedge clk);
        btn_raw = 1'b1;
        edges_to_step(n);
        btn_raw = 1'b0;
        edges_to_step(c);
        check(10 + n + c == TERM + 1, "R8 timer unaffected", 10 + n + c, TERM + 1);

        // R7 capture after step, hold on word change
        do_reset();
        btn_raw = 1'b1;
        edges_to_step(n);
        @(negedge clk);
        w = word_i[63:56];
        @(negedge clk);
        check(led_o == w, "R7 capture", led_o, w);
        held = led_o;
        noise = 64'hA5A5_0000_0000_0000;
        repeat (6) @(negedge clk);
        check(led_o == held, "R7 hold on word change", led_o, held);
        noise = 64'h0;
        btn_raw = 1'b0;

        // Free run with random button activity
        do_reset();
        for (int k = 0; k < 60; k++) begin
            btn_raw = $urandom_range(0, 1);
            repeat ($urandom_range(1, 12)) @(negedge clk);
        end
        btn_raw = 1'b0;
        repeat (20) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule